// File: doc/BRIEF.md
# Compiler-Scheduled Warp Issue Selector

This block is the issue stage of one scheduler sub-partition. It holds twelve resident warp slots. For each slot it receives the control bits of the next instruction that warp wants to issue. Each cycle it names at most one warp to issue. The compiler-written control bits decide when a warp may go. These are a static stall count, a yield hint, an optional barrier that the instruction arms, and a mask of barriers the instruction must wait on. No register-level dependency tracking is involved.

Each warp owns a stall down-counter and six dependency barriers. Each barrier is a small counter. Issuing an instruction that arms barrier b raises that counter. A completion pulse from a variable-latency unit, naming a warp and a barrier, lowers it. A warp is eligible when it presents a valid instruction, its stall counter is zero, and none of the barriers in its wait mask has a nonzero counter.

A small priority machine chooses among the eligible warps. It has three states:
- SEL_IDLE: nothing issued last cycle.
- SEL_KEEP: the last issue had no yield.
- SEL_PASS: the last issue had its yield bit set.

In SEL_KEEP the search begins at the last issued warp, so a warp that does not yield keeps issuing. In SEL_IDLE and SEL_PASS the search begins one past the last issued warp and wraps from 11 to 0. The transitions are the same from every state:
- No eligible warp: go to SEL_IDLE.
- Issue with yield: go to SEL_PASS.
- Issue without yield: go to SEL_KEEP.

The issue decision is combinational from the current state and inputs. It takes effect at the next rising clock edge.

Top module: `warp_issue_sel`

## Requirements
- R1: In any cycle at most one warp issues. When issue_valid is high, issue_warp is in 0..11 and names an eligible warp. issue_valid is low only when no warp is eligible.
- R2: A warp whose inst_valid bit is low is never selected.
- R3: If a warp issues in cycle t with stall count S (inst_stall field, 4 bits), it cannot issue again before cycle t+1+S. With S=0 it may issue in cycle t+1.
- R4: Bit b of a warp's 6-bit wait field (bit 0 is barrier 0, bit 5 is barrier 5) blocks that warp while its barrier b counter is nonzero.
- R5: Issuing an instruction with inst_set_en high increments the issuing warp's counter for the barrier given by its 3-bit inst_set_idx (values 0..5). Index values 6 and 7 arm nothing.
- R6: A completion pulse (cmpl_valid with cmpl_warp and cmpl_bar) decrements that barrier's counter. A barrier armed n times clears only after n pulses. The warp may issue in the cycle after the last pulse. A pulse on a zero counter has no effect.
- R7: Barrier state is private to each warp. A completion pulse naming another warp leaves a warp's barriers unchanged.
- R8: After an issue without yield (SEL_KEEP), the warp that just issued has first priority in the next cycle.
- R9: After an issue with yield (SEL_PASS) or a cycle with no issue (SEL_IDLE), the search begins at the warp after the last issued one, wrapping from 11 to 0.
- R10: After reset all stall counters and barrier counters are zero, the state is SEL_IDLE, and the last-issued pointer is 11, so the search begins at warp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 12 | Per-warp: a next instruction is present |
| inst_stall | input | 48 | Per-warp 4-bit stall count, warp w at bits [4w+3:4w] |
| inst_yield | input | 12 | Per-warp yield hint |
| inst_set_en | input | 12 | Per-warp: instruction arms a barrier |
| inst_set_idx | input | 36 | Per-warp 3-bit barrier index to arm, warp w at [3w+2:3w] |
| inst_wait | input | 72 | Per-warp 6-bit wait mask, warp w at [6w+5:6w] |
| cmpl_valid | input | 1 | Completion pulse from a variable-latency unit |
| cmpl_warp | input | 4 | Warp the completion belongs to |
| cmpl_bar | input | 3 | Barrier the completion releases |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_warp | output | 4 | Index of the issuing warp |

## Verification
The hardest state to reach from the ports is a barrier that is armed several times and then only partly released. Reaching it also means showing that a stray release, either to another warp or to an already-empty counter, changes nothing. The bench arms one barrier twice by letting the same warp issue on two back-to-back cycles with the arm bit set. It then switches the instruction to one that waits on that barrier. It sends one matching pulse, one pulse to a different warp, and a final matching pulse, and after each it checks that issue stays blocked until the last one. An extra pulse on the empty counter, followed by a fresh arm and wait, shows that the spurious pulse was not banked as credit.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
    typedef enum logic [1:0] {
        SEL_IDLE = 2'd0,
        SEL_KEEP = 2'd1,
        SEL_PASS = 2'd2
    } sel_state_t;
endpackage

// File: rtl/warp_slot.sv
// Per-warp stall counter and barrier counters; produces eligibility.
module warp_slot #(
    parameter int NUM_BARS = 6,
    parameter int STALL_W  = 4,
    parameter int CNT_W    = 3,
    parameter int BIDX_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inst_valid,
    input  logic                issue,
    input  logic [STALL_W-1:0]  stall_in,
    input  logic                set_en,
    input  logic [BIDX_W-1:0]   set_idx,
    input  logic [NUM_BARS-1:0] wait_mask,
    input  logic                cmpl_hit,
    input  logic [BIDX_W-1:0]   cmpl_idx,
    output logic                eligible
);
    logic [STALL_W-1:0]  stall_q;
    logic [NUM_BARS-1:0] busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= '0;
        end else if (issue) begin
            stall_q <= stall_in;
        end else if (stall_q != '0) begin
            stall_q <= stall_q - 1'b1;
        end
    end

    for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
        logic [CNT_W-1:0] cnt_q;
        logic             inc;
        logic             dec;

        assign inc = issue && set_en && (set_idx == BIDX_W'(b));
        assign dec = cmpl_hit && (cmpl_idx == BIDX_W'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (inc && !dec && (cnt_q != {CNT_W{1'b1}})) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (dec && !inc && (cnt_q != '0)) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign busy[b] = |cnt_q;
    end

    assign eligible = inst_valid && (stall_q == '0) && ((busy & wait_mask) == '0);
endmodule

// File: rtl/warp_rr_pick.sv
// Picks the first eligible warp at or after a rotating start position.
module warp_rr_pick #(
    parameter int NUM_WARPS = 12,
    parameter int WID_W     = 4
) (
    input  logic [NUM_WARPS-1:0] elig,
    input  logic [WID_W-1:0]     start,
    output logic                 found,
    output logic [WID_W-1:0]     pick
);
    always_comb begin
        int pos;
        found = 1'b0;
        pick  = '0;
        // Walk from the farthest offset back to offset zero so the nearest wins.
        for (int k = NUM_WARPS - 1; k >= 0; k--) begin
            pos = int'(start) + k;
            if (pos >= NUM_WARPS) begin
                pos = pos - NUM_WARPS;
            end
            if (elig[pos]) begin
                found = 1'b1;
                pick  = WID_W'(pos);
            end
        end
    end
endmodule

// File: rtl/warp_issue_sel.sv
module warp_issue_sel
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 12,
    parameter int NUM_BARS  = 6,
    parameter int STALL_W   = 4,
    parameter int CNT_W     = 3,
    localparam int WID_W    = $clog2(NUM_WARPS),
    localparam int BIDX_W   = $clog2(NUM_BARS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WARPS-1:0]          inst_valid,
    input  logic [NUM_WARPS*STALL_W-1:0]  inst_stall,
    input  logic [NUM_WARPS-1:0]          inst_yield,
    input  logic [NUM_WARPS-1:0]          inst_set_en,
    input  logic [NUM_WARPS*BIDX_W-1:0]   inst_set_idx,
    input  logic [NUM_WARPS*NUM_BARS-1:0] inst_wait,
    input  logic                          cmpl_valid,
    input  logic [WID_W-1:0]              cmpl_warp,
    input  logic [BIDX_W-1:0]             cmpl_bar,
    output logic                          issue_valid,
    output logic [WID_W-1:0]              issue_warp
);
    localparam logic [WID_W-1:0] LAST_IDX = WID_W'(NUM_WARPS - 1);

    sel_state_t            state_q, state_d;
    logic [WID_W-1:0]      last_q;
    logic [WID_W-1:0]      start;
    logic [NUM_WARPS-1:0]  elig_vec;
    logic                  found;
    logic [WID_W-1:0]      pick;
    logic                  pick_yield;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        warp_slot #(
            .NUM_BARS (NUM_BARS),
            .STALL_W  (STALL_W),
            .CNT_W    (CNT_W),
            .BIDX_W   (BIDX_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .inst_valid (inst_valid[w]),
            .issue      (issue_valid && (issue_warp == WID_W'(w))),
            .stall_in   (inst_stall[w*STALL_W +: STALL_W]),
            .set_en     (inst_set_en[w]),
            .set_idx    (inst_set_idx[w*BIDX_W +: BIDX_W]),
            .wait_mask  (inst_wait[w*NUM_BARS +: NUM_BARS]),
            .cmpl_hit   (cmpl_valid && (cmpl_warp == WID_W'(w))),
            .cmpl_idx   (cmpl_bar),
            .eligible   (elig_vec[w])
        );
    end

    warp_rr_pick #(
        .NUM_WARPS (NUM_WARPS),
        .WID_W     (WID_W)
    ) u_pick (
        .elig  (elig_vec),
        .start (start),
        .found (found),
        .pick  (pick)
    );

    assign pick_yield = inst_yield[pick];

    // State register and last-issued pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEL_IDLE;
            last_q  <= LAST_IDX;
        end else begin
            state_q <= state_d;
            if (found) begin
                last_q <= pick;
            end
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_IDLE, SEL_KEEP, SEL_PASS: begin
                if (!found) begin
                    state_d = SEL_IDLE;
                end else if (pick_yield) begin
                    state_d = SEL_PASS;
                end else begin
                    state_d = SEL_KEEP;
                end
            end
            default: state_d = SEL_IDLE;
        endcase
    end

    // Outputs: search start and issue decision.
    always_comb begin
        start = (last_q == LAST_IDX) ? '0 : last_q + 1'b1;
        unique case (state_q)
            SEL_KEEP: start = last_q;
            SEL_IDLE, SEL_PASS: start = (last_q == LAST_IDX) ? '0 : last_q + 1'b1;
            default: start = '0;
        endcase
        issue_valid = found;
        issue_warp  = pick;
    end
endmodule

// File: rtl/warp_issue_sel_chk.sv
module warp_issue_sel_chk #(
    parameter int NUM_WARPS = 12,
    parameter int STALL_W   = 4,
    parameter int WID_W     = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         issue_valid,
    input logic [WID_W-1:0]             issue_warp,
    input logic [NUM_WARPS-1:0]         inst_valid,
    input logic [NUM_WARPS*STALL_W-1:0] inst_stall,
    input logic [NUM_WARPS-1:0]         elig
);
    logic [STALL_W-1:0] cur_stall;

    always_comb begin
        cur_stall = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (issue_warp == WID_W'(w)) begin
                cur_stall = inst_stall[w*STALL_W +: STALL_W];
            end
        end
    end

    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (int'(issue_warp) < NUM_WARPS));

    p_pick_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> elig[issue_warp]);

    p_conserve_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |-> issue_valid);

    p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> inst_valid[issue_warp]);

    p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_valid) && ($past(cur_stall) != '0))
        |-> !(issue_valid && (issue_warp == $past(issue_warp))));
endmodule

bind warp_issue_sel warp_issue_sel_chk #(
    .NUM_WARPS (NUM_WARPS),
    .STALL_W   (STALL_W),
    .WID_W     (WID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_warp  (issue_warp),
    .inst_valid  (inst_valid),
    .inst_stall  (inst_stall),
    .elig        (elig_vec)
);

// File: tb/warp_issue_sel_bench.sv
module warp_issue_sel_bench;
    localparam int NW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] inst_valid = '0;
    logic [47:0]   inst_stall = '0;
    logic [NW-1:0] inst_yield = '0;
    logic [NW-1:0] inst_set_en = '0;
    logic [35:0]   inst_set_idx = '0;
    logic [71:0]   inst_wait = '0;
    logic          cmpl_valid = 1'b0;
    logic [3:0]    cmpl_warp = '0;
    logic [2:0]    cmpl_bar = '0;
    logic          issue_valid;
    logic [3:0]    issue_warp;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    warp_issue_sel u_warp_issue_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .inst_valid   (inst_valid),
        .inst_stall   (inst_stall),
        .inst_yield   (inst_yield),
        .inst_set_en  (inst_set_en),
        .inst_set_idx (inst_set_idx),
        .inst_wait    (inst_wait),
        .cmpl_valid   (cmpl_valid),
        .cmpl_warp    (cmpl_warp),
        .cmpl_bar     (cmpl_bar),
        .issue_valid  (issue_valid),
        .issue_warp   (issue_warp)
    );

    // {valid mask, yield, expected issue_valid, expected warp}
    localparam logic [17:0] VEC [13] = '{
        {12'h000, 1'b0, 1'b0, 4'd0},
        {12'h024, 1'b0, 1'b1, 4'd2},
        {12'h024, 1'b0, 1'b1, 4'd2},
        {12'h024, 1'b1, 1'b1, 4'd2},
        {12'h024, 1'b0, 1'b1, 4'd5},
        {12'h801, 1'b1, 1'b1, 4'd11},
        {12'h801, 1'b1, 1'b1, 4'd0},
        {12'h801, 1'b0, 1'b1, 4'd11},
        {12'h801, 1'b0, 1'b1, 4'd11},
        {12'h000, 1'b0, 1'b0, 4'd0},
        {12'h801, 1'b0, 1'b1, 4'd0},
        {12'hFFF, 1'b1, 1'b1, 4'd0},
        {12'hFFF, 1'b1, 1'b1, 4'd1}
    };

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        inst_valid = '0; inst_stall = '0; inst_yield = '0;
        inst_set_en = '0; inst_set_idx = '0; inst_wait = '0;
        cmpl_valid = 1'b0; cmpl_warp = '0; cmpl_bar = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic [11:0] v, input logic [3:0] st, input logic y,
                        input logic se, input logic [2:0] si, input logic [5:0] wm,
                        input logic cv, input logic [3:0] cw, input logic [2:0] cb,
                        input logic ev, input logic [3:0] ew, input string tag);
        @(negedge clk);
        inst_valid   = v;
        inst_stall   = {NW{st}};
        inst_yield   = {NW{y}};
        inst_set_en  = {NW{se}};
        inst_set_idx = {NW{si}};
        inst_wait    = {NW{wm}};
        cmpl_valid   = cv;
        cmpl_warp    = cw;
        cmpl_bar     = cb;
        #2;
        checks++;
        if (issue_valid !== ev || (ev && issue_warp !== ew)) begin
            fails++;
            $display("FAIL %s: actual valid=%0b warp=%0d, expected valid=%0b warp=%0d",
                     tag, issue_valid, issue_warp, ev, ew);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual run still going, expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        // R10: reset state, search begins at warp 0, no barrier outstanding
        do_reset();
        step(12'h000, 4'd0, 1'b0, 1'b0, 3'd0, 6'h00, 1'b0, 4'd0, 3'd0, 1'b0, 4'd0, "R10 idle after reset");
        step(12'hFFF, 4'd0, 1'b0, 1'b0, 3'd0, 6'h3F, 1'b0, 4'd0, 3'd0, 1'b1, 4'd0, "R10 start at warp 0");

        // Priority table: R1, R2, R8, R9
        do_reset();
        for (int i = 0; i < 13; i++) begin
            step(VEC[i][17:6], 4'd0, VEC[i][5], 1'b0, 3'd0, 6'h00, 1'b0, 4'd0, 3'd0,
                 VEC[i][4], VEC[i][3:0], "R1/R2/R8/R9 table");
        end

        // R3: stall count
        do_reset();
        step(12'h008, 4'd2, 1'b0, 1'b0, 3'd0, 6'h00, 1'b0, 4'd0, 3'd0, 1'b1, 4'd3, "R3 first issue");
        step(12'h008, 4'd2, 1'b0, 1'b0, 3'd0, 6'h00, 1'b0, 4'd0, 3'd0, 1'b0, 4'd0, "R3 stalled 1");
        step(12'h008, 4'd2, 1'b0, 1'b0, 3'd0, 6'h00, 1'b0, 4'd0, 3'd0, 1'b0, 4'd0, "R3 stalled 2");
        step(12'h008, 4'd0, 1'b0, 1'b0, 3'd0, 6'h00, 1'b0, 4'd0, 3'd0, 1'b1, 4'd3, "R3 stall expired");
        step(12'h008, 4'd0, 1'b0, 1'b0, 3'd0, 6'h00, 1'b0, 4'd0, 3'd0, 1'b1, 4'd3, "R3 zero stall back-to-back");

        // R4, R5, R6, R7: barrier armed twice then released
        do_reset();
        step(12'h002, 4'd0, 1'b0, 1'b1, 3'd2, 6'h00, 1'b0, 4'd0, 3'd0, 1'b1, 4'd1, "R5 arm once");
        step(12'h002, 4'd0, 1'b0, 1'b1, 3'd2, 6'h00, 1'b0, 4'd0, 3'd0, 1'b1, 4'd1, "R5 arm twice");
        step(12'h002, 4'd0, 1'b0, 1'b0, 3'd0, 6'h04, 1'b1, 4'd1, 3'd2, 1'b0, 4'd0, "R4 wait blocks");
        step(12'h002, 4'd0, 1'b0, 1'b0, 3'd0, 6'h04, 1'b1, 4'd0, 3'd2, 1'b0, 4'd0, "R6 partial release");
        step(12'h002, 4'd0, 1'b0, 1'b0, 3'd0, 6'h04, 1'b1, 4'd1, 3'd2, 1'b0, 4'd0, "R7 other warp pulse");
        step(12'h002, 4'd0, 1'b0, 1'b0, 3'd0, 6'h04, 1'b1, 4'd1, 3'd2, 1'b1, 4'd1, "R6 cleared");
        step(12'h002, 4'd0, 1'b0, 1'b1, 3'd2, 6'h00, 1'b0, 4'd0, 3'd0, 1'b1, 4'd1, "R5 re-arm");
        step(12'h002, 4'd0, 1'b0, 1'b0, 3'd0, 6'h04, 1'b0, 4'd0, 3'd0, 1'b0, 4'd0, "R6 empty-counter pulse ignored");

        // R5: index out of range arms nothing
        do_reset();
        step(12'h001, 4'd0, 1'b0, 1'b1, 3'd6, 6'h00, 1'b0, 4'd0, 3'd0, 1'b1, 4'd0, "R5 arm index 6");
        step(12'h001, 4'd0, 1'b0, 1'b0, 3'd0, 6'h3F, 1'b0, 4'd0, 3'd0, 1'b1, 4'd0, "R5 index 6 no effect");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule